// File: doc/BRIEF.md
# Fibonacci-Step Redundant Successive-Approximation Controller

This block is the digital search engine of a successive-approximation converter. It makes more comparisons than the converter has output bits. After a start pulse it puts out a mid-scale reference code and then reads one comparator decision per clock. Each decision moves the reference up or down by the next step size. The step sizes come from a descending Fibonacci schedule, not from halving. Because of the redundant steps, a wrong decision taken while the input is close to the reference is pulled back by the later steps. Such errors come from slow DAC settling or comparator noise.

When the last decision has been taken, the controller forms the final code from the last reference and the last decision, and clamps it to the output range. It presents the code with a one-cycle done strobe. The analog DAC, comparator and sample-and-hold sit outside the block. The reference output is a signed code, because the search can step slightly below zero or above full scale.

Top module: `sar_fib_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0, and code_o and ref_o are 0.
- R2: A start_i pulse seen while idle sets busy_o in the next cycle, with ref_o equal to mid-scale 2^(N_BITS-1) (8 for 4 bits).
- R3: In every busy cycle except the last, comp_i is sampled. The next ref_o is the current one plus the step weight when comp_i is 1 (input above reference), or minus it when comp_i is 0. With 6 steps the weights are 5, 3, 2, 1, 1, in that order.
- R4: busy_o stays high for exactly N_STEPS cycles (6), one decision per cycle. done_o follows in the cycle after the last busy cycle, with busy_o low.
- R5: The final code is the last reference plus the last decision minus one, saturated to the range 0 to 2^N_BITS-1.
- R6: start_i while busy_o is high has no effect on the reference sequence, the conversion length or the result.
- R7: With correct decisions, every input between 0 and 16 LSB (never an integer) converts to its floor.
- R8: One wrong decision at step k (1 to 4) still gives the floor of the input, provided that the input lies closer to that step's reference than 3, 2, 1 or 1 LSB respectively.
- R9: done_o is high for exactly one cycle per conversion, and code_o changes only in a cycle where done_o is high.
- R10: A comparator stuck at 1 gives code 15, and one stuck at 0 gives code 0, through saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start pulse, taken only while idle |
| comp_i | input | 1 | Comparator decision, 1 when the input exceeds ref_o |
| busy_o | output | 1 | Conversion in progress |
| ref_o | output | N_BITS+2 | Signed reference code driven to the DAC |
| done_o | output | 1 | One-cycle strobe marking a valid code_o |
| code_o | output | N_BITS | Corrected, saturated conversion result |

## Verification
Assertions check on every cycle that the first busy cycle shows mid-scale, and that each non-final step moves the reference in the direction of the sampled decision. They also check that done is a single-cycle pulse outside busy, that it arrives after exactly N_STEPS busy cycles, and that the code only changes with done. Only the bench scenarios can show what the correction buys. They sweep the whole input range at fractional offsets, inject a single wrong decision inside each step's margin, force stuck comparators into saturation and send starts during a conversion. These runs show that the Fibonacci schedule still lands on the floor of the input.

// File: rtl/sar_fib_pkg.sv
package sar_fib_pkg;
  function automatic int fib(input int n);
    int a, b, t;
    a = 0;
    b = 1;
    for (int i = 0; i < n; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  typedef enum logic {ST_IDLE, ST_CONV} sar_state_e;
endpackage

// File: rtl/sar_fib_sched.sv
module sar_fib_sched #(
  parameter int N_STEPS = 6,
  parameter int W_W     = 6,
  localparam int STEP_W = $clog2(N_STEPS)
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [W_W-1:0]    weight_o
);
  logic [W_W-1:0] tbl [N_STEPS];

  // weight for step k is F(N_STEPS-1-k); final entry unused
  for (genvar k = 0; k < N_STEPS; k++) begin : g_w
    assign tbl[k] = W_W'(sar_fib_pkg::fib(N_STEPS - 1 - k));
  end

  assign weight_o = tbl[step_i];
endmodule

// File: rtl/sar_fib_fsm.sv
module sar_fib_fsm #(
  parameter int N_STEPS = 6,
  localparam int STEP_W = $clog2(N_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o,
  output logic              load_o,
  output logic              adv_o,
  output logic              fin_o
);
  import sar_fib_pkg::*;

  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  sar_state_e  state_q;
  logic [STEP_W-1:0] step_q;
  logic        done_q;

  assign busy_o = (state_q == ST_CONV);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign adv_o  = busy_o && (step_q != LAST);
  assign fin_o  = busy_o && (step_q == LAST);
  assign step_o = step_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) begin
        state_q <= ST_CONV;
        step_q  <= '0;
      end else if (adv_o) begin
        step_q <= step_q + 1'b1;
      end else if (fin_o) begin
        state_q <= ST_IDLE;
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (step_q <= LAST)); // R4
  AST_FIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> (!busy_o && done_o)); // R4
endmodule

// File: rtl/sar_fib_datapath.sv
module sar_fib_datapath #(
  parameter int N_BITS = 4,
  parameter int REF_W  = N_BITS + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    adv_i,
  input  logic                    fin_i,
  input  logic                    comp_i,
  input  logic [REF_W-1:0]        weight_i,
  output logic signed [REF_W-1:0] ref_o,
  output logic [N_BITS-1:0]       code_o
);
  localparam logic signed [REF_W-1:0] MID      = REF_W'(2 ** (N_BITS - 1));
  localparam logic signed [REF_W:0]   CODE_MAX = (REF_W + 1)'(2 ** N_BITS - 1);

  logic signed [REF_W-1:0] ref_q;
  logic [N_BITS-1:0]       code_q;
  logic signed [REF_W:0]   cand;
  logic [N_BITS-1:0]       sat_code;

  // last decision selects ref or ref-1 as the floor estimate
  always_comb begin
    cand = {ref_q[REF_W-1], ref_q};
    if (!comp_i) cand = cand - (REF_W + 1)'(1);
    if (cand[REF_W])          sat_code = '0;
    else if (cand > CODE_MAX) sat_code = '1;
    else                      sat_code = cand[N_BITS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      code_q <= '0;
    end else begin
      if (load_i)     ref_q <= MID;
      else if (adv_i) ref_q <= comp_i ? ref_q + $signed(weight_i) : ref_q - $signed(weight_i);
      if (fin_i)      code_q <= sat_code;
    end
  end

  assign ref_o  = ref_q;
  assign code_o = code_q;

  AST_ADV_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ref_q != $past(ref_q))); // R3
  AST_CODE_ONLY_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(code_q)); // R9
endmodule

// File: rtl/sar_fib_ctrl.sv
module sar_fib_ctrl #(
  parameter int N_BITS  = 4,
  parameter int N_STEPS = 6,
  localparam int REF_W  = N_BITS + 2,
  localparam int STEP_W = $clog2(N_STEPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    comp_i,
  output logic                    busy_o,
  output logic signed [REF_W-1:0] ref_o,
  output logic                    done_o,
  output logic [N_BITS-1:0]       code_o
);
  logic [STEP_W-1:0] step;
  logic [REF_W-1:0]  weight;
  logic              load, adv, fin;

  sar_fib_fsm #(.N_STEPS(N_STEPS)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .step_o (step),
    .load_o (load),
    .adv_o  (adv),
    .fin_o  (fin)
  );

  sar_fib_sched #(.N_STEPS(N_STEPS), .W_W(REF_W)) u_sched (
    .step_i  (step),
    .weight_o(weight)
  );

  sar_fib_datapath #(.N_BITS(N_BITS), .REF_W(REF_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (adv),
    .fin_i   (fin),
    .comp_i  (comp_i),
    .weight_i(weight),
    .ref_o   (ref_o),
    .code_o  (code_o)
  );

  localparam logic signed [REF_W-1:0] MID = REF_W'(2 ** (N_BITS - 1));

  logic [STEP_W:0] chk_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_cnt <= '0;
    else if (!busy_o) chk_cnt <= '0;
    else              chk_cnt <= chk_cnt + 1'b1;
  end

  AST_START_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && ref_o == MID)); // R2
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && comp_i) |=> (ref_o > $past(ref_o))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !comp_i) |=> (ref_o < $past(ref_o))); // R3
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chk_cnt == (STEP_W + 1)'(N_STEPS))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(code_o)); // R9
endmodule

// File: tb/sar_fib_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_fib_ctrl_tb_top;
  localparam int N = 4;
  localparam int M = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic comp = 1'b0;
  logic busy, done;
  logic signed [N+1:0] ref_w;
  logic [N-1:0] code;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 0;

  int wts[M-1] = '{5, 3, 2, 1, 1};
  int margin[M] = '{3, 2, 1, 1, 0, 0};

  always #2 clk = ~clk;

  sar_fib_ctrl #(.N_BITS(N), .N_STEPS(M)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .comp_i(comp),
    .busy_o(busy), .ref_o(ref_w), .done_o(done), .code_o(code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural cycle model
  bit m_busy, m_done;
  int m_ref, m_step, m_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ref = 0; m_step = 0; m_code = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin m_busy = 1; m_ref = 2 ** (N - 1); m_step = 0; end
      end else if (m_step == M - 1) begin
        int c;
        c = m_ref + (comp ? 1 : 0) - 1;
        if (c < 0) c = 0;
        if (c > 2 ** N - 1) c = 2 ** N - 1;
        m_code = c; m_done = 1; m_busy = 0;
      end else begin
        m_ref = comp ? m_ref + wts[m_step] : m_ref - wts[m_step];
        m_step++;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      chk(busy == m_busy, "R4 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R9 done", int'(done), int'(m_done));
      chk(int'(code) == m_code, "R5 code", int'(code), m_code);
      if (m_busy)
        chk(int'(ref_w) == m_ref, (m_step == 0) ? "R2 ref" : "R3 ref", int'(ref_w), m_ref);
    end
  end

  // mode 0 ideal, 1 stuck high, 2 stuck low
  task automatic convert(input int vin10, input int err, input int mode, input bit poke,
                         input int exp_code, input string tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    for (int j = 0; j < M; j++) begin
      int d;
      bit c;
      d = vin10 - 10 * int'(ref_w);
      c = (d > 0);
      if (mode == 1) c = 1'b1;
      else if (mode == 2) c = 1'b0;
      else if (j == err && ((d < 0) ? -d : d) < 10 * margin[j]) c = !c;
      comp = c;
      start = poke && (j == 2);
      @(negedge clk);
    end
    start = 1'b0;
    comp = 1'b0;
    chk(done == 1'b1, tag, int'(done), 1);
    chk(int'(code) == exp_code, tag, int'(code), exp_code);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R4 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int fr[3] = '{1, 5, 9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags", int'({busy, done}), 0);
    chk(code == '0 && ref_w == '0, "R1 data", int'(ref_w), 0);
    mon_en = 1;
    for (int i = 0; i < 16; i++) begin
      for (int f = 0; f < 3; f++) begin
        int v;
        v = 10 * i + fr[f];
        convert(v, -1, 0, 0, i, "R7 floor");
        for (int e = 0; e < 4; e++) convert(v, e, 0, 0, i, "R8 flipped");
      end
    end
    convert(83, -1, 0, 1, 8, "R6 start ignored");
    convert(47, 0, 0, 1, 4, "R6 start ignored");
    convert(159, -1, 1, 0, 15, "R10 stuck high");
    convert(1, -1, 2, 0, 0, "R10 stuck low");
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 idle", int'({busy, done}), 0);
    summary();
    $finish;
  end
endmodule